// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block produces the column address for every beat of one SDRAM burst. A controller strobes `load_i` together with a 9-bit starting column whenever it issues a read or write column command. The block then presents one column per clock on `col_o`, holds `valid_o` high for the beats of the burst, and raises `last_o` on the final beat of a finite burst. The controller can cut a burst short with `term_i`. A new load may come on any clock, including the clock right after the previous one, and it restarts the sequence at once.

The burst is set by a 3-bit length code and a one-bit order select. Finite bursts of 2, 4 or 8 beats stay inside the aligned block that holds the start column. They step through that block either by counting upward with wrap-around or by XOR-ing the start column with the beat index. In full-page mode the address counts upward through the whole 512-column row, wraps from 511 to 0, and runs until it is terminated. A write-single option makes every write command a one-beat transfer, while reads keep the programmed length.

A small state machine has three states. IDLE has no burst. FIXED is a finite burst that is counting beats. PAGE is a full-page burst. The transitions are named as follows. IDLE→FIXED and IDLE→PAGE are *start*, taken on a load. FIXED→IDLE is *finish*, taken on the last beat or on terminate. PAGE→IDLE is *stop*, taken on terminate only. FIXED→FIXED and PAGE→PAGE on a load are *restart*. Otherwise a busy state stays where it is and advances its beat counter (*advance*).

Top module: `sdram_burst_colgen`

## Requirements
- R1: While reset is asserted and after it is released with no load, `valid_o` and `last_o` are 0.
- R2: On the clock after `load_i` is sampled high, `valid_o` is 1 and `col_o` equals the sampled `start_col_i`.
- R3: The `bl_code_i` value picks the burst length. Codes 0, 1, 2 and 3 give 1, 2, 4 and 8 beats. Code 7 selects full page. Codes 4, 5 and 6 act as 1 beat. A finite burst keeps `valid_o` high for exactly its length, raises `last_o` only on its final beat, and drops `valid_o` on the clock after that.
- R4: When `btype_i`=0 (sequential) with length L, beat n has its low log2(L) bits equal to (start+n) mod L. The bits above them equal those of the start column.
- R5: When `btype_i`=1 (interleaved) with length L, beat n has its low log2(L) bits equal to start XOR n. The bits above them equal those of the start column.
- R6: In full-page mode, beat n is (start+n) mod 512 whatever `btype_i` holds. `last_o` stays 0, and the burst continues until it is terminated or reloaded.
- R7: If `term_i` is high while `valid_o` is 1 and `load_i` is low, the current beat is the last one and `valid_o` is 0 on the next clock.
- R8: If `cmd_write_i`=1 and `single_wr_i`=1 at the load, the burst is exactly one beat with `last_o`=1, whatever the length code.
- R9: A load during a burst restarts at once from the new start column. A load takes precedence over `term_i` in the same clock.
- R10: `term_i` while no burst is active has no effect, and `valid_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Column command strobe, starts a burst |
| start_col_i | input | 9 | Starting column of the burst |
| cmd_write_i | input | 1 | 1 = the column command is a write |
| bl_code_i | input | 3 | Burst length code (0:1, 1:2, 2:4, 3:8, 7:full page, others:1) |
| btype_i | input | 1 | Burst order: 0 sequential, 1 interleaved |
| single_wr_i | input | 1 | 1 = writes always transfer one beat |
| term_i | input | 1 | Ends the active burst after the current beat |
| col_o | output | 9 | Column address of the current beat |
| valid_o | output | 1 | A beat is being presented |
| last_o | output | 1 | The current beat is the final beat of a finite burst |

## Verification
The bench targets start columns near the top of an aligned block and near column 511. A design that carried the increment into the upper bits would leave its block or fail to wrap the row. Interleaved bursts from odd starts are run, because an adder used in place of an XOR gives the wrong order there. Full-page bursts are requested with the interleaved bit set, and they must still count upward and never raise `last_o`. The bench also issues loads one clock apart, loads together with terminate, terminate while idle, reserved length codes and single-beat writes. These catch a design that lets a burst run on after a reload, gives terminate priority, or keeps the programmed length for writes.

// File: rtl/colgen_pkg.sv
package colgen_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FIXED = 2'd1,
        ST_PAGE  = 2'd2
    } cg_state_e;

    localparam logic [2:0] BLC_ONE  = 3'd0;
    localparam logic [2:0] BLC_TWO  = 3'd1;
    localparam logic [2:0] BLC_FOUR = 3'd2;
    localparam logic [2:0] BLC_EIGHT = 3'd3;
    localparam logic [2:0] BLC_PAGE = 3'd7;

    localparam logic BT_SEQ = 1'b0;
    localparam logic BT_ITL = 1'b1;

endpackage

// File: rtl/colgen_cfg_decode.sv
module colgen_cfg_decode
    import colgen_pkg::*;
#(
    parameter int COL_W   = 9,
    parameter int MAX_LOG = 3
) (
    input  logic [2:0]       bl_code,
    input  logic             cmd_write,
    input  logic             single_wr,
    input  logic             btype,
    output logic [COL_W-1:0] wrap_mask,
    output logic             page,
    output logic             interleave
);
    localparam int LG_W = $clog2(COL_W + 1);

    logic [LG_W-1:0] lg;
    logic            one_beat_write;

    always_comb begin
        one_beat_write = cmd_write & single_wr;
        page           = 1'b0;
        lg             = '0;
        if (one_beat_write) begin
            lg = '0;
        end else if (bl_code == BLC_PAGE) begin
            page = 1'b1;
        end else if (int'(bl_code) <= MAX_LOG) begin
            lg = LG_W'(bl_code);
        end
        interleave = (btype == BT_ITL) && !page && !one_beat_write;
    end

    for (genvar i = 0; i < COL_W; i++) begin : g_mask
        assign wrap_mask[i] = page | (LG_W'(i) < lg);
    end

endmodule

// File: rtl/colgen_addr_calc.sv
module colgen_addr_calc #(
    parameter int COL_W = 9
) (
    input  logic [COL_W-1:0] base,
    input  logic [COL_W-1:0] beat,
    input  logic [COL_W-1:0] wrap_mask,
    input  logic             interleave,
    output logic [COL_W-1:0] col
);
    logic [COL_W-1:0] sum;

    assign sum = base + beat;

    for (genvar i = 0; i < COL_W; i++) begin : g_bit
        logic moved;
        assign moved  = interleave ? (base[i] ^ beat[i]) : sum[i];
        assign col[i] = wrap_mask[i] ? moved : base[i];
    end

endmodule

// File: rtl/colgen_fsm.sv
module colgen_fsm
    import colgen_pkg::*;
#(
    parameter int COL_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [COL_W-1:0] start_col,
    input  logic [COL_W-1:0] new_mask,
    input  logic             new_page,
    input  logic             new_itl,
    input  logic             term,
    output logic [COL_W-1:0] base,
    output logic [COL_W-1:0] beat,
    output logic [COL_W-1:0] wrap_mask,
    output logic             interleave,
    output logic             valid,
    output logic             last
);
    cg_state_e state_q, state_d;
    logic [COL_W-1:0] beat_d;
    logic             final_beat;

    assign final_beat = (beat == wrap_mask);

    always_comb begin
        state_d = state_q;
        beat_d  = beat;
        if (load) begin
            state_d = new_page ? ST_PAGE : ST_FIXED;
            beat_d  = '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    state_d = ST_IDLE;
                end
                ST_FIXED: begin
                    if (term || final_beat) state_d = ST_IDLE;
                    else                    beat_d  = beat + 1'b1;
                end
                ST_PAGE: begin
                    if (term) state_d = ST_IDLE;
                    else      beat_d  = beat + 1'b1;
                end
                default: begin
                    state_d = ST_IDLE;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            beat       <= '0;
            base       <= '0;
            wrap_mask  <= '0;
            interleave <= 1'b0;
        end else begin
            state_q <= state_d;
            beat    <= beat_d;
            if (load) begin
                base       <= start_col;
                wrap_mask  <= new_mask;
                interleave <= new_itl;
            end
        end
    end

    always_comb begin
        valid = 1'b0;
        last  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                valid = 1'b0;
            end
            ST_FIXED: begin
                valid = 1'b1;
                last  = final_beat;
            end
            ST_PAGE: begin
                valid = 1'b1;
            end
            default: begin
                valid = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/sdram_burst_colgen.sv
module sdram_burst_colgen
    import colgen_pkg::*;
#(
    parameter int COL_W   = 9,
    parameter int MAX_LOG = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [COL_W-1:0] start_col_i,
    input  logic             cmd_write_i,
    input  logic [2:0]       bl_code_i,
    input  logic             btype_i,
    input  logic             single_wr_i,
    input  logic             term_i,
    output logic [COL_W-1:0] col_o,
    output logic             valid_o,
    output logic             last_o
);
    logic [COL_W-1:0] dec_mask;
    logic             dec_page;
    logic             dec_itl;
    logic [COL_W-1:0] base;
    logic [COL_W-1:0] beat;
    logic [COL_W-1:0] wrap_mask;
    logic             interleave;

    colgen_cfg_decode #(.COL_W(COL_W), .MAX_LOG(MAX_LOG)) dec_i (
        .bl_code    (bl_code_i),
        .cmd_write  (cmd_write_i),
        .single_wr  (single_wr_i),
        .btype      (btype_i),
        .wrap_mask  (dec_mask),
        .page       (dec_page),
        .interleave (dec_itl)
    );

    colgen_fsm #(.COL_W(COL_W)) fsm_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load_i),
        .start_col  (start_col_i),
        .new_mask   (dec_mask),
        .new_page   (dec_page),
        .new_itl    (dec_itl),
        .term       (term_i),
        .base       (base),
        .beat       (beat),
        .wrap_mask  (wrap_mask),
        .interleave (interleave),
        .valid      (valid_o),
        .last       (last_o)
    );

    colgen_addr_calc #(.COL_W(COL_W)) addr_i (
        .base       (base),
        .beat       (beat),
        .wrap_mask  (wrap_mask),
        .interleave (interleave),
        .col        (col_o)
    );

endmodule

// File: rtl/colgen_checker.sv
module colgen_checker #(
    parameter int COL_W = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic             load_i,
    input logic [COL_W-1:0] start_col_i,
    input logic             cmd_write_i,
    input logic             single_wr_i,
    input logic             term_i,
    input logic [COL_W-1:0] col_o,
    input logic             valid_o,
    input logic             last_o
);
    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (!valid_o && !last_o));

    p_load_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (valid_o && col_o == $past(start_col_i)));

    p_last_in_burst_r3: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |-> valid_o);

    p_last_ends_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (last_o && !load_i) |=> !valid_o);

    p_beat_moves_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !last_o && !term_i && !load_i) |=> (valid_o && col_o != $past(col_o)));

    p_term_stops_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && term_i && !load_i) |=> !valid_o);

    p_write_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && cmd_write_i && single_wr_i) |=> last_o);

    p_idle_term_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid_o && term_i && !load_i) |=> !valid_o);

endmodule

bind sdram_burst_colgen colgen_checker #(.COL_W(COL_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_i      (load_i),
    .start_col_i (start_col_i),
    .cmd_write_i (cmd_write_i),
    .single_wr_i (single_wr_i),
    .term_i      (term_i),
    .col_o       (col_o),
    .valid_o     (valid_o),
    .last_o      (last_o)
);

// File: tb/sdram_burst_colgen_tb_top.sv
module sdram_burst_colgen_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 50000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       load_i = 1'b0;
    logic [8:0] start_col_i = '0;
    logic       cmd_write_i = 1'b0;
    logic [2:0] bl_code_i = '0;
    logic       btype_i = 1'b0;
    logic       single_wr_i = 1'b0;
    logic       term_i = 1'b0;
    logic [8:0] col_o;
    logic       valid_o;
    logic       last_o;

    int total = 0;
    int bad = 0;

    // reference model state
    bit m_valid = 1'b0;
    int m_start = 0;
    int m_n = 0;
    int m_len = 1;   // 0 means full page
    bit m_itl = 1'b0;
    string force_tag = "";

    always #(CLK_PERIOD/2) clk = ~clk;

    sdram_burst_colgen dut_i (
        .clk(clk), .rst_n(rst_n), .load_i(load_i), .start_col_i(start_col_i),
        .cmd_write_i(cmd_write_i), .bl_code_i(bl_code_i), .btype_i(btype_i),
        .single_wr_i(single_wr_i), .term_i(term_i),
        .col_o(col_o), .valid_o(valid_o), .last_o(last_o)
    );

    function automatic int len_of(bit [2:0] code, bit wr, bit single);
        if (wr && single) return 1;
        if (code == 3'd7) return 0;
        if (code <= 3'd3) return 1 << code;
        return 1;
    endfunction

    function automatic int exp_col(int start, int n, int len, bit itl);
        int mask;
        if (len == 0) return (start + n) % 512;
        mask = len - 1;
        if (itl) return (start & ~mask & 511) | ((start ^ n) & mask);
        return (start & ~mask & 511) | ((start + n) & mask);
    endfunction

    task automatic check(string tag, int act, int exp, string what);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic compare();
        string tv, tc;
        if (m_len == 0) tc = "R6"; else if (m_itl) tc = "R5"; else tc = "R4";
        tv = "R3";
        if (force_tag != "") begin tv = force_tag; tc = force_tag; end
        check(tv, int'(valid_o), int'(m_valid), "valid");
        check(tv, int'(last_o), int'(m_valid && m_len != 0 && m_n == m_len - 1), "last");
        if (m_valid) check(tc, int'(col_o), exp_col(m_start, m_n, m_len, m_itl), "col");
    endtask

    task automatic step(bit ld, int st, bit [2:0] code, bit bt, bit wr, bit sg, bit tm);
        load_i = ld; start_col_i = 9'(st); bl_code_i = code; btype_i = bt;
        cmd_write_i = wr; single_wr_i = sg; term_i = tm;
        @(posedge clk);
        #1;
        if (ld) begin
            m_valid = 1'b1; m_start = st; m_n = 0;
            m_len = len_of(code, wr, sg);
            m_itl = bt && m_len != 0 && !(wr && sg);
        end else if (m_valid) begin
            if (tm || (m_len != 0 && m_n == m_len - 1)) m_valid = 1'b0;
            else m_n = m_n + 1;
        end
        @(negedge clk);
        compare();
    endtask

    task automatic idle(int k);
        for (int i = 0; i < k; i++) step(0, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired (all R)");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240917));
        repeat (3) @(negedge clk);
        check("R1", int'(valid_o), 0, "valid in reset");
        check("R1", int'(last_o), 0, "last in reset");
        rst_n = 1'b1;
        force_tag = "R1";
        idle(2);
        force_tag = "";

        // R2 / R4: sequential BL4 from top of its block
        force_tag = "R2";
        step(1, 9'h1FD, 3'd2, 0, 0, 0, 0);
        force_tag = "";
        idle(4);
        // R4: BL8 sequential, odd start
        step(1, 9'h0A5, 3'd3, 0, 0, 0, 0); idle(8);
        // R5: interleaved BL8 and BL4
        step(1, 9'h0A5, 3'd3, 1, 0, 0, 0); idle(8);
        step(1, 9'h013, 3'd2, 1, 0, 0, 0); idle(4);
        // R3: BL1, BL2, reserved code 5
        step(1, 9'h1FF, 3'd0, 0, 0, 0, 0); idle(2);
        step(1, 9'h1FF, 3'd1, 1, 0, 0, 0); idle(2);
        step(1, 9'h044, 3'd5, 0, 0, 0, 0); idle(2);
        // R6: full page near the row end, interleave bit ignored
        step(1, 9'h1FC, 3'd7, 1, 0, 0, 0); idle(10);
        force_tag = "R7";
        step(0, 0, 0, 0, 0, 0, 1); idle(2);
        // R7: terminate mid BL8
        force_tag = "";
        step(1, 9'h020, 3'd3, 0, 0, 0, 0); idle(2);
        force_tag = "R7";
        step(0, 0, 0, 0, 0, 0, 1); idle(2);
        // R8: single-beat writes; read with option keeps length
        force_tag = "R8";
        step(1, 9'h031, 3'd3, 0, 1, 1, 0); idle(2);
        step(1, 9'h031, 3'd7, 0, 1, 1, 0); idle(2);
        step(1, 9'h031, 3'd2, 0, 0, 1, 0); idle(4);
        // R9: back-to-back loads, load with terminate
        force_tag = "R9";
        step(1, 9'h100, 3'd3, 0, 0, 0, 0); idle(1);
        step(1, 9'h107, 3'd3, 1, 0, 0, 0);
        step(1, 9'h10E, 3'd2, 0, 0, 0, 1);
        step(1, 9'h1F0, 3'd7, 0, 0, 0, 1); idle(3);
        step(0, 0, 0, 0, 0, 0, 1); idle(1);
        // R10: terminate while idle
        force_tag = "R10";
        step(0, 0, 0, 0, 0, 0, 1);
        step(0, 0, 0, 0, 0, 0, 1);
        force_tag = "";

        // constrained random
        for (int i = 0; i < 4000; i++) begin
            bit ld, tm;
            bit [2:0] code;
            ld = ($urandom % 6) == 0;
            tm = ($urandom % 12) == 0;
            code = 3'($urandom % 8);
            step(ld, int'($urandom % 512), code, 1'($urandom), 1'($urandom),
                 1'($urandom), tm);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule